// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out, in kHz, the frequency that a core clock tree is running at. It uses only the contents of two configuration registers. It takes the core clock select bit and the core PLL configuration word and pulls the reference divider, feedback multiplier and output divider fields out of the word. From those fields it computes the PLL output frequency relative to a fixed 33330 kHz reference. It also reports the bus clock, which always runs at half the core clock. It measures no real clock.

A caller pulses `start` for one cycle with the inputs valid. The block latches everything it needs on that edge. Some time later it raises `valid` for exactly one cycle, and the two results are valid in that cycle. The results stay on the outputs until the next computation completes.

The division by the reference divider is done one quotient bit per cycle, so a small controller sequences the work. The controller has four states:

- **IDLE** waits for `start`.
  - The *osc_pick* transition goes straight to DONE when the select bit chooses the oscillator.
  - The *pll_pick* transition goes to DIVIDE otherwise.
- **DIVIDE** runs one restoring-division step per cycle. The *div_finish* transition goes to SCALE after the last quotient bit.
- **SCALE** applies the power-of-two output divider as a right shift. The *scale_finish* transition then goes to DONE.
- **DONE** drives `valid`. The *report* transition returns it to IDLE.

Top module: `clkfreq_calc`

## Requirements
- R1: After reset, `valid` is low and `core_khz` and `bus_khz` are both 0.
- R2: The configuration word is decoded with fixed field positions. The reference divider is bits 5:0, the feedback multiplier is bits 14:6 and the output divider exponent is bits 17:15. Bits 31:18 have no effect on the results.
- R3: When `osc_sel` is 1 at `start`, `core_khz` is exactly 33330, whatever `pll_cfg` holds.
- R4: When `osc_sel` is 0 at `start`, `core_khz` is computed with truncating integer division, applied left to right. The computation is 33330 × 2 × (divf+1), then divided by (divr+1), then divided by 2^divq. This includes the extremes divr=63, divf=511 and divq=7.
- R5: `bus_khz` equals `core_khz` / 2, truncated, on every completion.
- R6: `valid` is high for exactly one cycle per accepted start. For the oscillator path it is high in the cycle after `start`. For the PLL path it is high DATA_W+2 cycles after `start`, which is 34 cycles for DATA_W=32.
- R7: `osc_sel` and `pll_cfg` are sampled only in the `start` cycle. Changing them afterwards does not change the result.
- R8: A `start` pulse that arrives while a computation is in progress is ignored. It produces no extra `valid` pulse and does not alter the result.
- R9: After `valid`, `core_khz` and `bus_khz` hold their values until the next completion, even if the inputs change.
- R10: The setting divr=0, divf=59, divq=2 yields `core_khz` = 999900 and `bus_khz` = 499950.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; inputs are sampled in this cycle |
| osc_sel | input | 1 | 1 selects the reference oscillator as core clock |
| pll_cfg | input | CFG_W | PLL configuration word |
| valid | output | 1 | One-cycle completion strobe |
| core_khz | output | DATA_W | Core clock frequency in kHz |
| bus_khz | output | DATA_W | Bus clock frequency in kHz |

## Verification
The embedded assertions check the following on every cycle:

- `valid` is a single-cycle pulse.
- The oscillator path completes in one cycle.
- The controller stays busy through DIVIDE and SCALE no matter what `start` does.
- The divider's partial remainder stays below the divisor, and its final quotient and remainder reconstruct the dividend exactly.
- The results stay steady after a report.

Some behaviours can only be shown by the bench's directed scenarios. These are:

- the absolute numeric values, such as 999900 and the divr=63/divq=7 corners;
- the field decoding and the insensitivity to bits 31:18;
- sampling at `start` only;
- the exact PLL-path latency.

The bench compares these against an independent arithmetic model.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;
    // Field layout of the PLL configuration word (decoded by clkfreq_fields)
    localparam int RDIV_LSB = 0;
    localparam int RDIV_W   = 6;
    localparam int FMUL_LSB = 6;
    localparam int FMUL_W   = 9;
    localparam int QEXP_LSB = 15;
    localparam int QEXP_W   = 3;
    localparam int FIELDS_TOP = QEXP_LSB + QEXP_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SCALE  = 2'd2,
        ST_DONE   = 2'd3
    } calc_state_t;
endpackage

// File: rtl/clkfreq_fields.sv
module clkfreq_fields
    import clkfreq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CFG_W   = 32,
    parameter int REF_KHZ = 33330
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [DATA_W-1:0] numer,
    output logic [DATA_W-1:0] denom,
    output logic [QEXP_W-1:0] qexp
);
    logic [RDIV_W-1:0] rdiv;
    logic [FMUL_W-1:0] fmul;

    always_comb begin
        rdiv  = cfg[RDIV_LSB +: RDIV_W];
        fmul  = cfg[FMUL_LSB +: FMUL_W];
        qexp  = cfg[QEXP_LSB +: QEXP_W];
        // VCO numerator: doubled reference times (multiplier + 1)
        numer = DATA_W'(2 * REF_KHZ) * ({{(DATA_W-FMUL_W){1'b0}}, fmul} + DATA_W'(1));
        denom = {{(DATA_W-RDIV_W){1'b0}}, rdiv} + DATA_W'(1);
    end
endmodule

// File: rtl/clkfreq_divider.sv
module clkfreq_divider #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] quotient,
    output logic              last
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] rem_q;
    logic [DATA_W-1:0] quo_q;
    logic [DATA_W-1:0] dvs_q;
    logic [DATA_W-1:0] dvd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fin_q;

    logic [DATA_W:0]   trial;
    logic [DATA_W:0]   diff;
    logic              fits;

    always_comb begin
        trial = {rem_q, quo_q[DATA_W-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dvd_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            dvd_q <= dividend;
            cnt_q <= CNT_W'(DATA_W - 1);
            fin_q <= 1'b0;
        end else if (step) begin
            rem_q <= fits ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
            quo_q <= {quo_q[DATA_W-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            fin_q <= (cnt_q == '0);
        end
    end

    assign quotient = quo_q;
    assign last     = (cnt_q == '0);

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q < dvs_q));

    // R4
    quot_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (({{DATA_W{1'b0}}, quo_q} * {{DATA_W{1'b0}}, dvs_q}
                    + {{DATA_W{1'b0}}, rem_q}) == {{DATA_W{1'b0}}, dvd_q}));
endmodule

// File: rtl/clkfreq_ctrl.sv
module clkfreq_ctrl
    import clkfreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic osc_sel,
    input  logic div_last,
    output logic div_load,
    output logic div_step,
    output logic scale_en,
    output logic osc_take,
    output logic valid
);
    calc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = osc_sel ? ST_DONE : ST_DIVIDE; // osc_pick / pll_pick
            end
            ST_DIVIDE: begin
                if (div_last) state_d = ST_SCALE;                   // div_finish
            end
            ST_SCALE: state_d = ST_DONE;                           // scale_finish
            ST_DONE:  state_d = ST_IDLE;                           // report
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        div_load = 1'b0;
        div_step = 1'b0;
        scale_en = 1'b0;
        osc_take = 1'b0;
        valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                div_load = start && !osc_sel;
                osc_take = start && osc_sel;
            end
            ST_DIVIDE: div_step = 1'b1;
            ST_SCALE:  scale_en = 1'b1;
            ST_DONE:   valid    = 1'b1;
            default: ;
        endcase
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    osc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && osc_sel) |=> valid);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE || state_q == ST_SCALE) |=> (state_q != ST_IDLE));

    // R8
    divide_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && !div_last) |=> (state_q == ST_DIVIDE));
endmodule

// File: rtl/clkfreq_calc.sv
module clkfreq_calc
    import clkfreq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CFG_W   = 32,
    parameter int REF_KHZ = 33330
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              osc_sel,
    input  logic [CFG_W-1:0]  pll_cfg,
    output logic              valid,
    output logic [DATA_W-1:0] core_khz,
    output logic [DATA_W-1:0] bus_khz
);
    logic [DATA_W-1:0] numer, denom, quotient, scaled;
    logic [QEXP_W-1:0] qexp, qexp_q;
    logic div_load, div_step, scale_en, osc_take, div_last;

    clkfreq_fields #(.DATA_W(DATA_W), .CFG_W(CFG_W), .REF_KHZ(REF_KHZ)) u_fields (
        .cfg   (pll_cfg),
        .numer (numer),
        .denom (denom),
        .qexp  (qexp)
    );

    clkfreq_divider #(.DATA_W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .step     (div_step),
        .dividend (numer),
        .divisor  (denom),
        .quotient (quotient),
        .last     (div_last)
    );

    clkfreq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .osc_sel  (osc_sel),
        .div_last (div_last),
        .div_load (div_load),
        .div_step (div_step),
        .scale_en (scale_en),
        .osc_take (osc_take),
        .valid    (valid)
    );

    assign scaled = quotient >> qexp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qexp_q   <= '0;
            core_khz <= '0;
            bus_khz  <= '0;
        end else begin
            if (div_load) qexp_q <= qexp;
            if (osc_take) begin
                core_khz <= DATA_W'(REF_KHZ);
                bus_khz  <= DATA_W'(REF_KHZ / 2);
            end else if (scale_en) begin
                core_khz <= scaled;
                bus_khz  <= scaled >> 1;
            end
        end
    end

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> ($stable(core_khz) && $stable(bus_khz)));

    // R5
    bus_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (bus_khz <= core_khz));
endmodule

// File: tb/test_clkfreq_calc.sv
module test_clkfreq_calc;
    localparam int W = 32;
    localparam int LAT_PLL = W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic osc_sel = 1'b0;
    logic [31:0] pll_cfg = '0;
    logic valid;
    logic [W-1:0] core_khz, bus_khz;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    clkfreq_calc i_clkfreq_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .osc_sel(osc_sel),
        .pll_cfg(pll_cfg), .valid(valid), .core_khz(core_khz), .bus_khz(bus_khz)
    );

    function automatic longint model_core(input logic sel, input logic [31:0] cfg);
        longint r, f, q;
        if (sel) return 33330;
        r = longint'(cfg[5:0]);
        f = longint'(cfg[14:6]);
        q = longint'(cfg[17:15]);
        return ((33330 * 2 * (f + 1)) / (r + 1)) / (longint'(1) << q);
    endfunction

    function automatic logic [31:0] mk_cfg(input int r, input int f, input int q);
        return {14'd0, q[2:0], f[8:0], r[5:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue a start and return after the negedge where valid is seen.
    task automatic run_calc(input logic sel, input logic [31:0] cfg, input bit scramble,
                            output int lat);
        @(negedge clk);
        start = 1'b1; osc_sel = sel; pll_cfg = cfg;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin osc_sel = ~sel; pll_cfg = ~cfg; end
        lat = 1;
        while (!valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input string req, input logic sel, input logic [31:0] cfg);
        longint e;
        e = model_core(sel, cfg);
        chk({req, " core"}, 64'(core_khz), 64'(e));
        chk("R5 bus", 64'(bus_khz), 64'(e / 2));
    endtask

    task automatic t_reset;
        chk("R1 valid", 64'(valid), 64'd0);
        chk("R1 core", 64'(core_khz), 64'd0);
        chk("R1 bus", 64'(bus_khz), 64'd0);
    endtask

    task automatic t_example;
        int lat;
        run_calc(1'b0, mk_cfg(0, 59, 2), 1'b0, lat);
        chk("R6 pll latency", 64'(lat), 64'(LAT_PLL));
        chk("R10 core", 64'(core_khz), 64'd999900);
        chk("R10 bus", 64'(bus_khz), 64'd499950);
        @(negedge clk);
        chk("R6 single pulse", 64'(valid), 64'd0);
    endtask

    task automatic t_osc;
        int lat;
        run_calc(1'b1, 32'h0003_FFFF, 1'b0, lat);
        chk("R6 osc latency", 64'(lat), 64'd1);
        chk("R3 core", 64'(core_khz), 64'd33330);
        chk("R3 bus", 64'(bus_khz), 64'd16665);
        @(negedge clk);
        chk("R6 osc single pulse", 64'(valid), 64'd0);
    endtask

    task automatic t_corners;
        int lat;
        run_calc(1'b0, mk_cfg(63, 511, 7), 1'b0, lat);
        chk("R4 max corner", 64'(core_khz), 64'd4166);
        run_calc(1'b0, mk_cfg(63, 0, 7), 1'b0, lat);
        chk("R4 min corner", 64'(core_khz), 64'd8);
        run_calc(1'b0, mk_cfg(0, 0, 0), 1'b0, lat);
        check_result("R4 zero fields", 1'b0, mk_cfg(0, 0, 0));
        run_calc(1'b0, mk_cfg(0, 511, 0), 1'b0, lat);
        check_result("R4 largest", 1'b0, mk_cfg(0, 511, 0));
    endtask

    task automatic t_fields;
        int lat;
        logic [31:0] base;
        base = mk_cfg(5, 100, 3);
        run_calc(1'b0, base | 32'hFFFC_0000, 1'b0, lat);
        check_result("R2 upper bits", 1'b0, base);
        run_calc(1'b0, mk_cfg(1, 2, 1), 1'b0, lat);
        chk("R2 field positions", 64'(core_khz), 64'd49995);
    endtask

    task automatic t_sample;
        int lat;
        run_calc(1'b0, mk_cfg(2, 40, 1), 1'b1, lat);
        check_result("R7 pll sampled", 1'b0, mk_cfg(2, 40, 1));
        run_calc(1'b1, mk_cfg(2, 40, 1), 1'b1, lat);
        chk("R7 osc sampled", 64'(core_khz), 64'd33330);
    endtask

    task automatic t_busy;
        int lat;
        int extra;
        @(negedge clk);
        start = 1'b1; osc_sel = 1'b0; pll_cfg = mk_cfg(3, 77, 1);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!valid && lat < 200) begin
            if (lat == 5) begin
                start = 1'b1; osc_sel = 1'b1; pll_cfg = mk_cfg(9, 9, 4);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R8 latency", 64'(lat), 64'(LAT_PLL));
        check_result("R8 result", 1'b0, mk_cfg(3, 77, 1));
        extra = 0;
        for (int i = 0; i < LAT_PLL + 4; i++) begin
            @(negedge clk);
            if (valid) extra++;
        end
        chk("R8 no extra valid", 64'(extra), 64'd0);
    endtask

    task automatic t_hold;
        int lat;
        run_calc(1'b0, mk_cfg(1, 200, 2), 1'b0, lat);
        osc_sel = 1'b1; pll_cfg = 32'hFFFF_FFFF;
        repeat (10) @(negedge clk);
        check_result("R9 hold", 1'b0, mk_cfg(1, 200, 2));
    endtask

    task automatic t_random;
        int lat;
        logic [31:0] cfg;
        for (int i = 0; i < 30; i++) begin
            cfg = $urandom();
            if (i == 0) cfg[17:15] = 3'd7;
            if (i == 1) cfg[5:0] = 6'd63;
            run_calc(1'b0, cfg, 1'b0, lat);
            check_result("R4 random", 1'b0, cfg);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R6 actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_example();
        t_osc();
        t_corners();
        t_fields();
        t_sample();
        t_busy();
        t_hold();
        t_random();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule